// File: doc/BRIEF.md
# Dual-direction character FIFO with DMA ready flags

This block buffers characters between a serial receiver and a host, and between the host and a serial transmitter. The receive queue stores each byte together with three error bits: parity, framing and break. Its ready logic treats a queued error as a reason to stop DMA, so the host must service the error by hand. The transmit queue asks for DMA refills based on how much free space it has, not on whether it is empty.

Each direction compares its fill, or its free space, against a trigger level. That level comes from one of four fixed fractions of the depth, or from a programmed value. While the queues are disabled, each direction acts as a single holding register and the trigger level is one. A character timeout from the receiver also counts as reaching the trigger. Any change of the enable input empties both queues.

Top module: `uart_fifo_dma`

## Requirements
- R1: After reset, both levels are 0, `rx_overrun` is 0, `rxrdy_n` is 1, `txrdy_n` is 0, `rx_irq` is 0 and `tx_irq` is 1.
- R2: Each queue returns entries in the order written. Each receive entry returns the error bits written with it. The head entry is visible on the read outputs while the level is non-zero.
- R3: Capacity is DEPTH (64) entries while `fifo_en` is 1 and one entry while it is 0. A write to a full queue with no read in the same cycle is dropped. A dropped write sets `rx_overrun` only on the receive side.
- R4: `rx_overrun` stays set until a cycle with `status_rd` high. If a dropped receive write and `status_rd` fall in the same cycle, the flag ends up set.
- R5: With `fifo_en` at 0, the trigger level is 1. Otherwise a non-zero programmed value is used as the trigger. A programmed value of 0 selects the fixed set instead. For DEPTH 64, the receive codes 0/1/2/3 give 8/16/56/60 and the transmit codes give 8/16/32/56.
- R6: `rxrdy_n` is 0 when the receive level is at least the trigger, or when `rx_timeout` is high with a non-empty queue, and no stored entry carries an error. In every other case it is 1, and it is always 1 when the queue is empty.
- R7: While any queued receive entry has a non-zero error field, `rxrdy_n` is 1. It returns to normal once the last such entry is read.
- R8: `txrdy_n` is 1 when the transmit queue is full. It is 0 when the free space is at least the trigger. Otherwise it keeps its previous value.
- R9: `rx_irq` is high when the receive level is at least the trigger, or when `rx_timeout` is high with a non-empty queue, whatever the error bits. `tx_irq` is high when the free space is at least the trigger.
- R10: A cycle in which `fifo_en` differs from its value in the previous cycle empties both queues. Writes in that cycle are discarded.
- R11: A write and a read in the same cycle on a full queue are both carried out. The level stays unchanged and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1: full-depth queues; 0: single holding entry |
| rx_trig_sel | input | 2 | Receive fixed trigger code |
| rx_trig_prog | input | 7 | Receive programmed trigger, 0 = use code |
| tx_trig_sel | input | 2 | Transmit fixed trigger code |
| tx_trig_prog | input | 7 | Transmit programmed trigger, 0 = use code |
| rx_wr | input | 1 | Receiver pushes a character |
| rx_wdata | input | 8 | Received byte |
| rx_werr | input | 3 | Error bits {break, framing, parity} |
| rx_rd | input | 1 | Host pops the receive head |
| rx_rdata | output | 8 | Receive head byte |
| rx_rerr | output | 3 | Receive head error bits |
| rx_level | output | 7 | Receive fill |
| rx_timeout | input | 1 | Character timeout from the receiver |
| status_rd | input | 1 | Host reads status; clears overrun |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| rx_irq | output | 1 | Receive trigger condition |
| rxrdy_n | output | 1 | Receive DMA request, active low |
| tx_wr | input | 1 | Host pushes a byte |
| tx_wdata | input | 8 | Byte to transmit |
| tx_rd | input | 1 | Transmitter pops the head |
| tx_rdata | output | 8 | Transmit head byte |
| tx_level | output | 7 | Transmit fill |
| tx_irq | output | 1 | Transmit free-space condition |
| txrdy_n | output | 1 | Transmit DMA request, active low |

## Verification
The overrun flag has a set and a clear that can land in the same cycle. The bench drives a write into a full receive queue together with a `status_rd` pulse, and expects the flag to read 1 afterwards. A second collision is a push and a pop in one cycle on a full queue. The bench judges it by an unchanged level of 64, a head that has moved to the second-oldest byte, and an overrun flag that stays clear.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
   localparam int BYTE_W = 8;
   localparam int ERRF_W = 3;
   localparam int RXE_W  = BYTE_W + ERRF_W;

   typedef struct packed {
      logic [ERRF_W-1:0] err;
      logic [BYTE_W-1:0] data;
   } rx_entry_t;
endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
   parameter int W     = 8,
   parameter int DEPTH = 64
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       flush,
   input  logic [$clog2(DEPTH+1)-1:0] cap,
   input  logic                       wr,
   input  logic [W-1:0]               wdata,
   input  logic                       rd,
   output logic [W-1:0]               rdata,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic                       full,
   output logic                       push,
   output logic                       pop
);
   localparam int  PTR_W = $clog2(DEPTH);
   localparam int  CNT_W = $clog2(DEPTH+1);
   localparam bit  POW2  = (DEPTH == (1 << PTR_W));

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_inc, rd_inc;
   logic [CNT_W-1:0] count;

   generate
      if (POW2) begin : g_pow2_wrap
         assign wr_inc = wr_ptr + 1'b1;
         assign rd_inc = rd_ptr + 1'b1;
      end else begin : g_cmp_wrap
         assign wr_inc = (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
         assign rd_inc = (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign full  = (count >= cap);
   assign pop   = rd && (count != '0) && !flush;
   assign push  = wr && (!full || pop) && !flush;
   assign level = count;
   assign rdata = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_inc;
         if (pop)  rd_ptr <= rd_inc;
         case ({push, pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   a_r3_level_within_cap: assert property (@(posedge clk) disable iff (rst)
      !flush |-> count <= cap);
   a_r3_full_write_dropped: assert property (@(posedge clk) disable iff (rst)
      (wr && full && !rd && !flush) |=> count == $past(count));
   a_r11_push_pop_keeps_level: assert property (@(posedge clk) disable iff (rst)
      (push && pop) |=> count == $past(count));
endmodule

// File: rtl/trigger_pick.sv
module trigger_pick #(
   parameter int DEPTH  = 64,
   parameter bit FOR_RX = 1'b1
) (
   input  logic                       en,
   input  logic [1:0]                 sel,
   input  logic [$clog2(DEPTH+1)-1:0] prog,
   output logic [$clog2(DEPTH+1)-1:0] trig
);
   localparam int CW = $clog2(DEPTH+1);
   logic [CW-1:0] fixed;

   generate
      if (FOR_RX) begin : g_rx_set
         always_comb begin
            case (sel)
               2'd0:    fixed = CW'(DEPTH/8);
               2'd1:    fixed = CW'(DEPTH/4);
               2'd2:    fixed = CW'((DEPTH*7)/8);
               default: fixed = CW'((DEPTH*15)/16);
            endcase
         end
      end else begin : g_tx_set
         always_comb begin
            case (sel)
               2'd0:    fixed = CW'(DEPTH/8);
               2'd1:    fixed = CW'(DEPTH/4);
               2'd2:    fixed = CW'(DEPTH/2);
               default: fixed = CW'((DEPTH*7)/8);
            endcase
         end
      end
   endgenerate

   assign trig = !en ? CW'(1) : ((prog != '0) ? prog : fixed);
endmodule

// File: rtl/rx_flags.sv
module rx_flags #(
   parameter int DEPTH = 64,
   parameter int EW    = 3
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       flush,
   input  logic                       wr,
   input  logic                       push,
   input  logic                       pop,
   input  logic [EW-1:0]              werr,
   input  logic [EW-1:0]              rerr,
   input  logic [$clog2(DEPTH+1)-1:0] level,
   input  logic [$clog2(DEPTH+1)-1:0] trig,
   input  logic                       timeout,
   input  logic                       status_rd,
   output logic                       overrun,
   output logic                       irq,
   output logic                       rdy_n
);
   localparam int CNT_W = $clog2(DEPTH+1);

   logic [CNT_W-1:0] err_cnt;
   logic             inc, dec, drop, hit;

   assign inc  = push && (werr != '0);
   assign dec  = pop  && (rerr != '0);
   assign drop = wr && !push && !flush;

   always_ff @(posedge clk) begin
      if (rst || flush) err_cnt <= '0;
      else if (inc && !dec) err_cnt <= err_cnt + CNT_W'(1);
      else if (dec && !inc) err_cnt <= err_cnt - CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst)            overrun <= 1'b0;
      else if (drop)      overrun <= 1'b1;
      else if (status_rd) overrun <= 1'b0;
   end

   assign hit   = (level >= trig) || (timeout && (level != '0));
   assign irq   = hit;
   assign rdy_n = !(hit && (err_cnt == '0));

   a_r4_drop_sets_overrun: assert property (@(posedge clk) disable iff (rst)
      drop |=> overrun);
   a_r7_errors_within_level: assert property (@(posedge clk) disable iff (rst)
      err_cnt <= level);
   a_r6_empty_never_ready: assert property (@(posedge clk) disable iff (rst)
      (level == '0) |-> rdy_n);
endmodule

// File: rtl/tx_flags.sv
module tx_flags #(
   parameter int DEPTH = 64
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [$clog2(DEPTH+1)-1:0] cap,
   input  logic [$clog2(DEPTH+1)-1:0] level,
   input  logic                       full,
   input  logic [$clog2(DEPTH+1)-1:0] trig,
   output logic                       irq,
   output logic                       rdy_n
);
   localparam int CNT_W = $clog2(DEPTH+1);

   logic [CNT_W-1:0] free;
   logic             held;

   assign free  = cap - level;
   assign irq   = (free >= trig);
   assign rdy_n = full ? 1'b1 : (irq ? 1'b0 : held);

   always_ff @(posedge clk) begin
      if (rst) held <= 1'b0;
      else     held <= rdy_n;
   end

   a_r8_full_blocks_request: assert property (@(posedge clk) disable iff (rst)
      (level >= cap) |-> rdy_n);
endmodule

// File: rtl/uart_fifo_dma.sv
module uart_fifo_dma
   import uart_fifo_pkg::*;
#(
   parameter int DEPTH = 64
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       fifo_en,
   input  logic [1:0]                 rx_trig_sel,
   input  logic [$clog2(DEPTH+1)-1:0] rx_trig_prog,
   input  logic [1:0]                 tx_trig_sel,
   input  logic [$clog2(DEPTH+1)-1:0] tx_trig_prog,
   input  logic                       rx_wr,
   input  logic [7:0]                 rx_wdata,
   input  logic [2:0]                 rx_werr,
   input  logic                       rx_rd,
   output logic [7:0]                 rx_rdata,
   output logic [2:0]                 rx_rerr,
   output logic [$clog2(DEPTH+1)-1:0] rx_level,
   input  logic                       rx_timeout,
   input  logic                       status_rd,
   output logic                       rx_overrun,
   output logic                       rx_irq,
   output logic                       rxrdy_n,
   input  logic                       tx_wr,
   input  logic [7:0]                 tx_wdata,
   input  logic                       tx_rd,
   output logic [7:0]                 tx_rdata,
   output logic [$clog2(DEPTH+1)-1:0] tx_level,
   output logic                       tx_irq,
   output logic                       txrdy_n
);
   localparam int CNT_W = $clog2(DEPTH+1);

   generate
      if (DEPTH < 16) begin : g_bad_depth
         $error("uart_fifo_dma: DEPTH must be at least 16");
      end
      if (BYTE_W != 8 || ERRF_W != 3) begin : g_bad_entry
         $error("uart_fifo_dma: entry layout must be 8 data plus 3 error bits");
      end
   endgenerate

   logic             en_q, flush;
   logic [CNT_W-1:0] cap, rx_trig, tx_trig;
   logic             rx_full, rx_push, rx_pop;
   logic             tx_full, tx_push, tx_pop;
   rx_entry_t        rx_in, rx_out;

   always_ff @(posedge clk) begin
      if (rst) en_q <= 1'b0;
      else     en_q <= fifo_en;
   end
   assign flush = (fifo_en != en_q);
   assign cap   = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);

   assign rx_in    = '{err: rx_werr, data: rx_wdata};
   assign rx_rdata = rx_out.data;
   assign rx_rerr  = rx_out.err;

   trigger_pick #(.DEPTH(DEPTH), .FOR_RX(1'b1)) i_rx_trig (
      .en(fifo_en), .sel(rx_trig_sel), .prog(rx_trig_prog), .trig(rx_trig));
   trigger_pick #(.DEPTH(DEPTH), .FOR_RX(1'b0)) i_tx_trig (
      .en(fifo_en), .sel(tx_trig_sel), .prog(tx_trig_prog), .trig(tx_trig));

   fifo_store #(.W(RXE_W), .DEPTH(DEPTH)) i_rx_store (
      .clk(clk), .rst(rst), .flush(flush), .cap(cap),
      .wr(rx_wr), .wdata(rx_in), .rd(rx_rd), .rdata(rx_out),
      .level(rx_level), .full(rx_full), .push(rx_push), .pop(rx_pop));

   fifo_store #(.W(BYTE_W), .DEPTH(DEPTH)) i_tx_store (
      .clk(clk), .rst(rst), .flush(flush), .cap(cap),
      .wr(tx_wr), .wdata(tx_wdata), .rd(tx_rd), .rdata(tx_rdata),
      .level(tx_level), .full(tx_full), .push(tx_push), .pop(tx_pop));

   rx_flags #(.DEPTH(DEPTH), .EW(ERRF_W)) i_rx_flags (
      .clk(clk), .rst(rst), .flush(flush), .wr(rx_wr),
      .push(rx_push), .pop(rx_pop), .werr(rx_werr), .rerr(rx_out.err),
      .level(rx_level), .trig(rx_trig), .timeout(rx_timeout),
      .status_rd(status_rd), .overrun(rx_overrun), .irq(rx_irq), .rdy_n(rxrdy_n));

   tx_flags #(.DEPTH(DEPTH)) i_tx_flags (
      .clk(clk), .rst(rst), .cap(cap), .level(tx_level), .full(tx_full),
      .trig(tx_trig), .irq(tx_irq), .rdy_n(txrdy_n));

   a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
      flush |=> (rx_level == '0) && (tx_level == '0));
   a_r2_tx_pop_needs_data: assert property (@(posedge clk) disable iff (rst)
      tx_pop |-> (tx_level != '0));
   a_r3_tx_push_grows: assert property (@(posedge clk) disable iff (rst)
      (tx_push && !tx_pop) |=> tx_level == $past(tx_level) + CNT_W'(1));
   a_r4_rx_full_full_flag: assert property (@(posedge clk) disable iff (rst)
      (rx_full && !fifo_en && !flush) |-> (rx_level == CNT_W'(1)));
endmodule

// File: tb/test_uart_fifo_dma.sv
module test_uart_fifo_dma;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 64;

   logic clk = 1'b0, rst = 1'b1, fifo_en = 1'b0;
   logic [1:0] rx_trig_sel = '0, tx_trig_sel = '0;
   logic [6:0] rx_trig_prog = '0, tx_trig_prog = '0;
   logic rx_wr = 0, rx_rd = 0, rx_timeout = 0, status_rd = 0, tx_wr = 0, tx_rd = 0;
   logic [7:0] rx_wdata = '0, tx_wdata = '0;
   logic [2:0] rx_werr = '0;
   logic [7:0] rx_rdata, tx_rdata;
   logic [2:0] rx_rerr;
   logic [6:0] rx_level, tx_level;
   logic rx_overrun, rx_irq, rxrdy_n, tx_irq, txrdy_n;

   int checks = 0, errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_fifo_dma #(.DEPTH(DEPTH)) i_uart_fifo_dma (
      .clk(clk), .rst(rst), .fifo_en(fifo_en),
      .rx_trig_sel(rx_trig_sel), .rx_trig_prog(rx_trig_prog),
      .tx_trig_sel(tx_trig_sel), .tx_trig_prog(tx_trig_prog),
      .rx_wr(rx_wr), .rx_wdata(rx_wdata), .rx_werr(rx_werr), .rx_rd(rx_rd),
      .rx_rdata(rx_rdata), .rx_rerr(rx_rerr), .rx_level(rx_level),
      .rx_timeout(rx_timeout), .status_rd(status_rd), .rx_overrun(rx_overrun),
      .rx_irq(rx_irq), .rxrdy_n(rxrdy_n), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
      .tx_rd(tx_rd), .tx_rdata(tx_rdata), .tx_level(tx_level),
      .tx_irq(tx_irq), .txrdy_n(txrdy_n));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic rx_push(input logic [7:0] d, input logic [2:0] e);
      @(negedge clk); rx_wr = 1; rx_wdata = d; rx_werr = e;
      @(negedge clk); rx_wr = 0; rx_werr = '0;
   endtask

   task automatic rx_pop();
      @(negedge clk); rx_rd = 1;
      @(negedge clk); rx_rd = 0;
   endtask

   task automatic tx_push(input logic [7:0] d);
      @(negedge clk); tx_wr = 1; tx_wdata = d;
      @(negedge clk); tx_wr = 0;
   endtask

   task automatic tx_pop();
      @(negedge clk); tx_rd = 1;
      @(negedge clk); tx_rd = 0;
   endtask

   task automatic status_pulse();
      @(negedge clk); status_rd = 1;
      @(negedge clk); status_rd = 0;
   endtask

   task automatic flush_all();
      @(negedge clk); fifo_en = 0;
      @(negedge clk); fifo_en = 1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 rx_level", rx_level, 0);
      check("R1 tx_level", tx_level, 0);
      check("R1 rxrdy_n", rxrdy_n, 1);
      check("R1 txrdy_n", txrdy_n, 0);
      check("R1 overrun", rx_overrun, 0);
      check("R1 rx_irq", rx_irq, 0);
      check("R1 tx_irq", tx_irq, 1);
   endtask

   task automatic t_disabled();
      rx_push(8'hA5, 3'b000);
      check("R3 one entry held", rx_level, 1);
      check("R5 R6 disabled trigger one", rxrdy_n, 0);
      rx_push(8'h11, 3'b000);
      check("R3 second write dropped", rx_level, 1);
      check("R3 dropped head intact", rx_rdata, 8'hA5);
      check("R3 overrun raised", rx_overrun, 1);
      status_pulse();
      check("R4 status read clears", rx_overrun, 0);
      tx_push(8'h3C);
      check("R8 tx full not ready", txrdy_n, 1);
      check("R2 tx head", tx_rdata, 8'h3C);
      tx_pop();
      check("R8 tx ready after pop", txrdy_n, 0);
      rx_pop();
      check("R6 empty not ready", rxrdy_n, 1);
   endtask

   task automatic t_order();
      @(negedge clk); fifo_en = 1; rx_trig_sel = 2'd0;
      @(negedge clk);
      for (int i = 0; i < 7; i++) rx_push(8'(i*3+1), 3'b000);
      check("R6 below trigger 8", rxrdy_n, 1);
      check("R9 irq below trigger", rx_irq, 0);
      rx_push(8'd22, 3'b000);
      check("R5 R6 trigger 8 reached", rxrdy_n, 0);
      check("R9 irq at trigger", rx_irq, 1);
      check("R2 head first", rx_rdata, 1);
      rx_pop();
      check("R6 back below trigger", rxrdy_n, 1);
      @(negedge clk); rx_timeout = 1; #1;
      check("R6 timeout ready", rxrdy_n, 0);
      check("R9 timeout irq", rx_irq, 1);
      @(negedge clk); rx_timeout = 0;
      for (int i = 1; i < 8; i++) begin
         check("R2 order", rx_rdata, i*3+1);
         rx_pop();
      end
      @(negedge clk); rx_timeout = 1; #1;
      check("R6 timeout on empty", rxrdy_n, 1);
      @(negedge clk); rx_timeout = 0;
   endtask

   task automatic t_error();
      rx_push(8'h10, 3'b000);
      rx_push(8'h11, 3'b000);
      rx_push(8'h12, 3'b010);
      for (int i = 0; i < 5; i++) rx_push(8'(8'h20 + i), 3'b000);
      check("R7 error blocks ready", rxrdy_n, 1);
      check("R9 irq despite error", rx_irq, 1);
      rx_pop(); rx_pop();
      check("R2 error bits at head", rx_rerr, 3'b010);
      check("R2 error data at head", rx_rdata, 8'h12);
      rx_pop();
      @(negedge clk); rx_timeout = 1; #1;
      check("R7 ready after error popped", rxrdy_n, 0);
      @(negedge clk); rx_timeout = 0;
      flush_all();
   endtask

   task automatic t_prog();
      rx_trig_prog = 7'd3;
      rx_push(8'h01, 3'b000); rx_push(8'h02, 3'b000);
      check("R5 prog 3 not reached", rxrdy_n, 1);
      rx_push(8'h03, 3'b000);
      check("R5 prog 3 reached", rxrdy_n, 0);
      @(negedge clk); rx_trig_prog = 7'd0; rx_trig_sel = 2'd3; #1;
      check("R5 zero prog uses code 3 (60)", rxrdy_n, 1);
      @(negedge clk); rx_trig_sel = 2'd0;
      flush_all();
   endtask

   task automatic t_full();
      for (int i = 0; i < DEPTH; i++) rx_push(8'(i), 3'b000);
      check("R3 capacity 64", rx_level, DEPTH);
      @(negedge clk); rx_wr = 1; rx_wdata = 8'hEE; status_rd = 1;
      @(negedge clk); rx_wr = 0; status_rd = 0;
      check("R4 set wins over clear", rx_overrun, 1);
      check("R3 full write dropped", rx_level, DEPTH);
      status_pulse();
      check("R4 cleared", rx_overrun, 0);
      @(negedge clk); rx_wr = 1; rx_rd = 1; rx_wdata = 8'h77;
      @(negedge clk); rx_wr = 0; rx_rd = 0;
      check("R11 level kept", rx_level, DEPTH);
      check("R11 no overrun", rx_overrun, 0);
      check("R11 head advanced", rx_rdata, 1);
      flush_all();
   endtask

   task automatic t_tx();
      tx_trig_sel = 2'd2;
      @(negedge clk);
      check("R8 empty ready", txrdy_n, 0);
      for (int i = 0; i < 32; i++) tx_push(8'(i));
      check("R8 free 32 ready", txrdy_n, 0);
      tx_push(8'd32);
      check("R8 free 31 holds low", txrdy_n, 0);
      check("R9 tx irq off", tx_irq, 0);
      for (int i = 33; i < DEPTH; i++) tx_push(8'(i));
      check("R8 full not ready", txrdy_n, 1);
      tx_push(8'hFF);
      check("R3 tx full drop", tx_level, DEPTH);
      check("R3 tx drop no overrun", rx_overrun, 0);
      check("R2 tx head", tx_rdata, 0);
      for (int i = 0; i < 31; i++) tx_pop();
      check("R8 free 31 holds high", txrdy_n, 1);
      tx_pop();
      check("R8 free 32 ready", txrdy_n, 0);
      check("R9 tx irq on", tx_irq, 1);
      check("R2 tx order", tx_rdata, 32);
   endtask

   task automatic t_flush();
      rx_push(8'h55, 3'b000);
      @(negedge clk); fifo_en = 0;
      @(negedge clk);
      check("R10 rx flushed", rx_level, 0);
      check("R10 tx flushed", tx_level, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_order();
      t_error();
      t_prog();
      t_full();
      t_tx();
      t_flush();
      done = 1;
      summary();
      $finish;
   end
endmodule